// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between a clocked host and an asynchronous static RAM. The host hands it one read or one write at a time through a valid/ready handshake. The block then drives the memory's chip select, write enable, address and data-out pins, plus the output-drive enable for the data pads, so that every minimum interval the memory needs is met in whole clock cycles. Read data is captured at a fixed point after the address has settled and is handed back with a one-cycle valid strobe.

All intervals are given in nanoseconds for three speed grades. They are turned into cycle counts during elaboration from the parameter `CLK_PERIOD_NS`, and `GRADE` picks the column. A write is framed by the overlap of chip select and write enable. Write enable always ends the write while chip select is still low. The data driver waits until the memory has let go of the bus, and it stops in the same cycle that write enable rises. The pads themselves are outside the block, which exposes data-out, drive-enable and data-in separately.

Top module: `sram_seq`

## Requirements
- R1: Every nanosecond minimum becomes ceil(ns / CLK_PERIOD_NS) cycles, with at least one cycle. The figures for GRADE 0, 1 and 2 are as follows. Write-enable pulse: 20, 30 and 35. Data setup: 12, 20 and 20. Select-to-write-end: 20, 30 and 40. Address-to-write-end: 20, 30 and 35. Both the cycle time and the access time: 25, 35 and 45. The bus release (8) and the address hold (5) are the same for every grade. These combine as follows:
  - WZ is the bus release in cycles and DW is the data setup in cycles.
  - WLOW is the largest of the pulse, WZ + DW, select-to-end and address-to-end.
  - HOLD is the larger of the address hold and (cycle time − WLOW).
  - RD is the larger of the access time and the cycle time.
- R2: `req_ready` is 1 when idle. A request is taken at a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from that edge until the transaction ends. `mem_cs_n` is 1 whenever `req_ready` is 1.
- R3: In the cycle after acceptance, `mem_cs_n` goes low and `mem_addr` shows the request address. The address stays unchanged for as long as `mem_cs_n` stays low.
- R4: For a write, `mem_we_n` falls in the same cycle as `mem_cs_n`. It stays low for exactly WLOW cycles and rises while `mem_cs_n` is still low.
- R5: `mem_dq_oe` rises exactly WZ cycles after `mem_we_n` falls and falls in the cycle that `mem_we_n` rises. While it is 1, `mem_dq_o` holds the request's write data unchanged.
- R6: After write enable rises, chip select stays low for HOLD more cycles, so the write keeps `mem_cs_n` low for WLOW + HOLD cycles in total. Then `mem_cs_n` and `req_ready` both return to 1 in the same cycle.
- R7: For a read, `mem_cs_n` is low, `mem_we_n` is 1 and `mem_dq_oe` is 0. `mem_dq_i` is captured at the RD-th rising edge after chip select fell. `rsp_valid` is then 1 for exactly one cycle with `rsp_rdata` equal to the captured value, and `mem_cs_n` and `req_ready` return to 1 at the same time.
- R8: While `rst_n` is 0 (asynchronous), `mem_cs_n` = 1, `mem_we_n` = 1, `mem_dq_oe` = 0, `req_ready` = 1 and `rsp_valid` = 0.
- R9: A `req_valid` raised while `req_ready` is 0 is ignored. It does not change the memory pins of the running transaction, and it is not stored for later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period assumed to be CLK_PERIOD_NS |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Sequencer can take a request |
| rsp_valid | output | 1 | One-cycle strobe, read data valid |
| rsp_rdata | output | DATA_W | Captured read data |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_o | output | DATA_W | Data toward the pads |
| mem_dq_oe | output | 1 | Pad drive enable for mem_dq_o |
| mem_dq_i | input | DATA_W | Data from the pads |

## Verification
The bench builds the block with CLK_PERIOD_NS = 4, GRADE = 0, an 8-bit address and 16-bit data. At these values the write-enable pulse and the release-plus-setup path tie at five cycles, and the address-hold and cycle-time limits tie at two cycles of hold. A single rounding error in any of these terms therefore changes a pin edge. Because the bench's memory model only returns valid data once the address has been stable for the full access count, a capture one edge early reads a marker value. The expected counts for the other two grades are tabulated in the bench, so setting its grade constant reaches the select-to-end-dominated and access-time-dominated cases.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WR_LOW  = 2'd1,
        ST_WR_HOLD = 2'd2,
        ST_RD_WAIT = 2'd3
    } seq_state_e;

    typedef enum int unsigned {
        TK_WE_PULSE,
        TK_DATA_SETUP,
        TK_CS_TO_END,
        TK_ADDR_TO_END,
        TK_CYCLE,
        TK_ACCESS,
        TK_BUS_RELEASE,
        TK_ADDR_HOLD
    } tkind_e;

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    // Ceiling division with a floor of one cycle.
    function automatic int ns_to_cyc(int ns, int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    // Minimum interval in ns per speed grade (0 fastest, 2 slowest).
    function automatic int grade_ns(int grade, tkind_e kind);
        int g;
        g = (grade < 0) ? 0 : ((grade > 2) ? 2 : grade);
        case (kind)
            TK_WE_PULSE:    return (g == 0) ? 20 : ((g == 1) ? 30 : 35);
            TK_DATA_SETUP:  return (g == 0) ? 12 : 20;
            TK_CS_TO_END:   return (g == 0) ? 20 : ((g == 1) ? 30 : 40);
            TK_ADDR_TO_END: return (g == 0) ? 20 : ((g == 1) ? 30 : 35);
            TK_CYCLE:       return (g == 0) ? 25 : ((g == 1) ? 35 : 45);
            TK_ACCESS:      return (g == 0) ? 25 : ((g == 1) ? 35 : 45);
            TK_BUS_RELEASE: return 8;
            TK_ADDR_HOLD:   return 5;
            default:        return 1;
        endcase
    endfunction

endpackage

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
    import sram_seq_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 16,
    parameter int WZ_CYC   = 2,
    parameter int WLOW_CYC = 5,
    parameter int HOLD_CYC = 2,
    parameter int RD_CYC   = 7,
    parameter int CNT_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              cs_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe,
    output logic              sample_stb
);

    localparam logic [CNT_W-1:0] WZ_VAL    = CNT_W'(WZ_CYC);
    localparam logic [CNT_W-1:0] WLOW_LAST = CNT_W'(WLOW_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] RD_LAST   = CNT_W'(RD_CYC - 1);

    typedef struct packed {
        seq_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic              cs_n;
        logic              we_n;
        logic              oe;
        logic              ready;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } ctrl_regs_t;

    localparam ctrl_regs_t REGS_RESET = '{
        state: ST_IDLE, cnt: '0, cs_n: 1'b1, we_n: 1'b1, oe: 1'b0,
        ready: 1'b1, addr: '0, wdata: '0
    };

    ctrl_regs_t r_d, r_q;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        r_d        = r_q;
        cnt_inc    = r_q.cnt + 1'b1;
        sample_stb = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    r_d.cs_n  = 1'b0;
                    r_d.ready = 1'b0;
                    r_d.cnt   = '0;
                    if (req_write) begin
                        r_d.we_n  = 1'b0;
                        r_d.state = ST_WR_LOW;
                    end else begin
                        r_d.state = ST_RD_WAIT;
                    end
                end
            end
            ST_WR_LOW: begin
                r_d.cnt = cnt_inc;
                r_d.oe  = (cnt_inc >= WZ_VAL);
                if (r_q.cnt == WLOW_LAST) begin
                    r_d.we_n  = 1'b1;
                    r_d.oe    = 1'b0;
                    r_d.cnt   = '0;
                    r_d.state = ST_WR_HOLD;
                end
            end
            ST_WR_HOLD: begin
                r_d.cnt = cnt_inc;
                if (r_q.cnt == HOLD_LAST) begin
                    r_d.cs_n  = 1'b1;
                    r_d.ready = 1'b1;
                    r_d.cnt   = '0;
                    r_d.state = ST_IDLE;
                end
            end
            ST_RD_WAIT: begin
                r_d.cnt = cnt_inc;
                if (r_q.cnt == RD_LAST) begin
                    sample_stb = 1'b1;
                    r_d.cs_n   = 1'b1;
                    r_d.ready  = 1'b1;
                    r_d.cnt    = '0;
                    r_d.state  = ST_IDLE;
                end
            end
            default: r_d = REGS_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RESET;
        else        r_q <= r_d;
    end

    assign req_ready = r_q.ready;
    assign cs_n      = r_q.cs_n;
    assign we_n      = r_q.we_n;
    assign addr      = r_q.addr;
    assign dq_o      = r_q.wdata;
    assign dq_oe     = r_q.oe;

endmodule

// File: rtl/sram_seq_capture.sv
module sram_seq_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_stb,
    input  logic [DATA_W-1:0] dq_i,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } cap_regs_t;

    cap_regs_t c_d, c_q;

    always_comb begin
        c_d       = c_q;
        c_d.valid = sample_stb;
        if (sample_stb) c_d.data = dq_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign rsp_valid = c_q.valid;
    assign rsp_rdata = c_q.data;

endmodule

// File: rtl/sram_seq.sv
module sram_seq
    import sram_seq_pkg::*;
#(
    parameter int ADDR_W        = 16,
    parameter int DATA_W        = 16,
    parameter int CLK_PERIOD_NS = 4,
    parameter int GRADE         = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);

    localparam int WP_CYC   = ns_to_cyc(grade_ns(GRADE, TK_WE_PULSE),    CLK_PERIOD_NS);
    localparam int DW_CYC   = ns_to_cyc(grade_ns(GRADE, TK_DATA_SETUP),  CLK_PERIOD_NS);
    localparam int CW_CYC   = ns_to_cyc(grade_ns(GRADE, TK_CS_TO_END),   CLK_PERIOD_NS);
    localparam int AW_CYC   = ns_to_cyc(grade_ns(GRADE, TK_ADDR_TO_END), CLK_PERIOD_NS);
    localparam int WC_CYC   = ns_to_cyc(grade_ns(GRADE, TK_CYCLE),       CLK_PERIOD_NS);
    localparam int AA_CYC   = ns_to_cyc(grade_ns(GRADE, TK_ACCESS),      CLK_PERIOD_NS);
    localparam int WZ_CYC   = ns_to_cyc(grade_ns(GRADE, TK_BUS_RELEASE), CLK_PERIOD_NS);
    localparam int WR_CYC   = ns_to_cyc(grade_ns(GRADE, TK_ADDR_HOLD),   CLK_PERIOD_NS);

    localparam int WLOW_CYC = imax(imax(WP_CYC, WZ_CYC + DW_CYC), imax(CW_CYC, AW_CYC));
    localparam int HOLD_CYC = imax(WR_CYC, WC_CYC - WLOW_CYC);
    localparam int RD_CYC   = imax(AA_CYC, WC_CYC);
    localparam int MAX_CYC  = imax(imax(WLOW_CYC, HOLD_CYC), RD_CYC);
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    logic sample_stb;

    sram_seq_ctrl #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .WZ_CYC   (WZ_CYC),
        .WLOW_CYC (WLOW_CYC),
        .HOLD_CYC (HOLD_CYC),
        .RD_CYC   (RD_CYC),
        .CNT_W    (CNT_W)
    ) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_ready  (req_ready),
        .cs_n       (mem_cs_n),
        .we_n       (mem_we_n),
        .addr       (mem_addr),
        .dq_o       (mem_dq_o),
        .dq_oe      (mem_dq_oe),
        .sample_stb (sample_stb)
    );

    sram_seq_capture #(
        .DATA_W (DATA_W)
    ) cap_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_stb (sample_stb),
        .dq_i       (mem_dq_i),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata)
    );

endmodule

// File: rtl/sram_seq_chk.sv
module sram_seq_chk #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 16,
    parameter int WLOW_CYC = 5,
    parameter int DW_MIN   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              mem_cs_n,
    input logic              mem_we_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_dq_o,
    input logic              mem_dq_oe
);

    int unsigned we_run;
    int unsigned drv_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_run  <= 0;
            drv_run <= 0;
        end else begin
            we_run  <= mem_we_n  ? 0 : we_run + 1;
            drv_run <= mem_dq_oe ? drv_run + 1 : 0;
        end
    end

    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> mem_cs_n); // R2
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr)); // R3
    AST_WE_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_cs_n); // R4
    AST_WE_RISE_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> !mem_cs_n); // R4
    AST_WE_LOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_run == WLOW_CYC)); // R4
    AST_DRV_OFF_AT_WE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> !mem_dq_oe); // R5
    AST_DRV_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> !mem_we_n); // R5
    AST_DRV_RUN_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_dq_oe) |-> (mem_we_n && drv_run >= DW_MIN)); // R5
    AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_o)); // R5
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R7
    AST_RSP_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (req_ready && mem_we_n)); // R7

endmodule

bind sram_seq sram_seq_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .WLOW_CYC (WLOW_CYC),
    .DW_MIN   (DW_CYC)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_cs_n  (mem_cs_n),
    .mem_we_n  (mem_we_n),
    .mem_addr  (mem_addr),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_seq_tb_top.sv
module sram_seq_tb_top;

    localparam int TB_GRADE = 0;
    localparam int AW = 8;
    localparam int DWD = 16;

    // Hand-derived cycle counts at a 4 ns period (R1).
    localparam int EXP_WZ   = 2;
    localparam int EXP_DW   = (TB_GRADE == 0) ? 3 : 5;
    localparam int EXP_WLOW = (TB_GRADE == 0) ? 5 : ((TB_GRADE == 1) ? 8 : 10);
    localparam int EXP_TOT  = (TB_GRADE == 0) ? 7 : ((TB_GRADE == 1) ? 10 : 12);
    localparam int EXP_RD   = (TB_GRADE == 0) ? 7 : ((TB_GRADE == 1) ? 9 : 12);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DWD-1:0] req_wdata = '0;
    logic req_ready, rsp_valid, mem_cs_n, mem_we_n, mem_dq_oe;
    logic [DWD-1:0] rsp_rdata, mem_dq_o, mem_dq_i;
    logic [AW-1:0] mem_addr;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    sram_seq #(.ADDR_W(AW), .DATA_W(DWD), .CLK_PERIOD_NS(4), .GRADE(TB_GRADE)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_cs_n(mem_cs_n),
        .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DWD-1:0] init_val(logic [AW-1:0] a);
        return {~a, a};
    endfunction

    // Memory contents: mem is what the pins actually wrote, shadow is what the host asked for.
    logic [DWD-1:0] mem [256];
    logic [DWD-1:0] shadow [256];
    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = init_val(AW'(i));
            shadow[i] = init_val(AW'(i));
        end
    end

    // Reference model, one step per rising edge.
    int t = -1;
    bit m_wr = 1'b0;
    logic [AW-1:0] m_a = '0;
    logic [DWD-1:0] m_d = '0;
    logic e_cs_n = 1'b1, e_we_n = 1'b1, e_oe = 1'b0, e_ready = 1'b1, e_rsp = 1'b0;
    logic [DWD-1:0] e_rdata = '0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t = -1; e_cs_n = 1; e_we_n = 1; e_oe = 0; e_ready = 1; e_rsp = 0;
        end else begin
            e_rsp = 0;
            if (t < 0) begin
                if (req_valid && e_ready) begin
                    t = 0; m_wr = req_write; m_a = req_addr; m_d = req_wdata;
                    if (m_wr) shadow[m_a] = m_d;
                end
            end else begin
                t = t + 1;
                if (m_wr && t == EXP_TOT) t = -1;
                else if (!m_wr && t == EXP_RD) begin
                    e_rsp = 1; e_rdata = shadow[m_a]; t = -1;
                end
            end
            if (t < 0) begin
                e_cs_n = 1; e_we_n = 1; e_oe = 0; e_ready = 1;
            end else begin
                e_cs_n = 0;
                e_we_n = m_wr ? (t >= EXP_WLOW) : 1'b1;
                e_oe = m_wr && t >= EXP_WZ && t < EXP_WLOW;
                e_ready = 0;
            end
        end
    end

    // Pin-level memory model and interval monitor, sampled on the falling edge.
    int we_run = 0, drv_run = 0, pre_drv = 0, cs_run = 0, rd_stable = 0;
    bit w_seen = 0, cs_wr = 0;
    logic [DWD-1:0] drv_data = '0;
    logic [AW-1:0] rd_addr = '0;

    assign mem_dq_i = (!mem_cs_n && mem_we_n && rd_stable >= EXP_RD) ? mem[mem_addr] : 16'hDEAD;

    always @(negedge clk) begin
        if (!rst_n) begin
            we_run = 0; drv_run = 0; pre_drv = 0; cs_run = 0; rd_stable = 0;
            w_seen = 0; cs_wr = 0;
        end else begin
            if (!mem_cs_n && !mem_we_n) begin
                w_seen = 1; we_run++;
                if (mem_dq_oe) begin drv_run++; drv_data = mem_dq_o; end
                else if (drv_run == 0) pre_drv++;
            end else if (w_seen) begin
                chk("R1", "we low cycles", we_run, EXP_WLOW);
                chk("R5", "driver delay after we fall", pre_drv, EXP_WZ);
                chk("R5", "driver on cycles", drv_run, EXP_WLOW - EXP_WZ);
                chk("R4", "cs low when we rises", int'(mem_cs_n), 0);
                chk("R5", "data at end of write", int'(drv_data), int'(m_d));
                mem[mem_addr] = (drv_run >= EXP_DW && !mem_cs_n) ? drv_data : 16'hBAD0;
                we_run = 0; drv_run = 0; pre_drv = 0; w_seen = 0;
            end
            if (!mem_cs_n) begin
                cs_run++;
                if (!mem_we_n) cs_wr = 1;
            end else if (cs_run > 0) begin
                chk(cs_wr ? "R6" : "R7", "cs low cycles", cs_run, cs_wr ? EXP_TOT : EXP_RD);
                cs_run = 0; cs_wr = 0;
            end
            if (!mem_cs_n && mem_we_n)
                rd_stable = (rd_stable > 0 && mem_addr == rd_addr) ? rd_stable + 1 : 1;
            else
                rd_stable = 0;
            rd_addr = mem_addr;
        end
    end

    // Cycle-by-cycle comparison against the reference model.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3", "cs_n", int'(mem_cs_n), int'(e_cs_n));
            chk("R4", "we_n", int'(mem_we_n), int'(e_we_n));
            chk("R5", "dq_oe", int'(mem_dq_oe), int'(e_oe));
            chk("R2", "req_ready", int'(req_ready), int'(e_ready));
            chk("R7", "rsp_valid", int'(rsp_valid), int'(e_rsp));
            if (!e_cs_n) chk("R3", "mem_addr", int'(mem_addr), int'(m_a));
            if (e_oe) chk("R5", "mem_dq_o", int'(mem_dq_o), int'(m_d));
            if (e_rsp) chk("R7", "rsp_rdata", int'(rsp_rdata), int'(e_rdata));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            failures++;
            $display("FAIL R2 watchdog actual=%0d expected=<100000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic do_req(bit wr, logic [AW-1:0] a, logic [DWD-1:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic read_expect(logic [AW-1:0] a, logic [DWD-1:0] exp, string req);
        do_req(0, a, '0);
        for (int n = 0; n < 64 && !rsp_valid; n++) @(negedge clk);
        chk(req, "read data", int'(rsp_rdata), int'(exp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R8", "reset cs_n", int'(mem_cs_n), 1);
        chk("R8", "reset we_n", int'(mem_we_n), 1);
        chk("R8", "reset dq_oe", int'(mem_dq_oe), 0);
        chk("R8", "reset ready", int'(req_ready), 1);
        chk("R8", "reset rsp_valid", int'(rsp_valid), 0);
        rst_n = 1;

        do_req(1, 8'h00, 16'h1234);
        do_req(1, 8'hFF, 16'hFFFF);
        do_req(1, 8'h5A, 16'h0000);
        do_req(1, 8'h01, 16'hA5C3);
        read_expect(8'h00, 16'h1234, "R7");
        read_expect(8'hFF, 16'hFFFF, "R7");
        read_expect(8'h5A, 16'h0000, "R7");
        read_expect(8'h01, 16'hA5C3, "R7");
        do_req(1, 8'h10, 16'hBEEF);
        read_expect(8'h10, 16'hBEEF, "R5");
        read_expect(8'h33, init_val(8'h33), "R7");

        // R9: a request raised while busy must leave the running write untouched.
        do_req(1, 8'h20, 16'h1111);
        req_valid = 1; req_write = 1; req_addr = 8'h21; req_wdata = 16'h2222;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R9", "addr while busy request held", int'(mem_addr), 8'h20);
            chk("R9", "ready while busy", int'(req_ready), 0);
        end
        req_valid = 0;
        read_expect(8'h21, init_val(8'h21), "R9");
        read_expect(8'h20, 16'h1111, "R9");

        for (int i = 0; i < 40; i++) begin
            logic [AW-1:0] a;
            a = AW'(i * 37);
            if (i % 3 == 2) read_expect(a, shadow[a], "R7");
            else do_req(1, a, DWD'(i * 4099) ^ 16'h5A5A);
        end

        @(negedge clk);
        while (!req_ready) @(negedge clk);
        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule